// File: doc/BRIEF.md
# Per-Line Edge Detector with Interrupt

This block watches a bank of 8-bit input ports for signal transitions. Every line carries two enable bits, one for upward and one for downward transitions; a line can watch either direction, both, or neither. The port lines arrive already synchronized to the block clock. Each sample is compared with the sample one clock earlier. Any enabled transition sets sticky status flags, which stay set until the host clears them with a strobe.

If another enabled transition arrives while the status is still set, an overflow flag records that an event was missed. One interrupt output combines the sticky flags through per-source enables and a global enable. Every detected transition also starts a trigger pulse of fixed length, about 200 ns, on a chosen set of trigger lines. The pulse restarts if a new transition arrives while it is running.

Top module: `edgemon_top`

## Requirements
- R1: A line whose upward enable bit is 1 and whose sample goes from 0 to 1 between two consecutive clocks sets `rise_sts` and `edge_sts` at the next clock edge. Line b of port p is bit p*8+b of `port_in`, and the enable bits use the same position.
- R2: A line whose downward enable bit is 1 and whose sample goes from 1 to 0 sets `fall_sts` and `edge_sts` at the next clock edge. A line with both enable bits set reports both directions.
- R3: A transition on a line whose enable bit for that direction is 0 changes no status flag and starts no trigger pulse.
- R4: The status flags are sticky. A one-cycle `clr_edge` strobe clears `rise_sts`, `fall_sts` and `edge_sts` at the next clock edge.
- R5: `ovf_sts` is set when an enabled transition is detected while `edge_sts` is already 1. It is not set by the first transition, and a one-cycle `clr_ovf` strobe clears it.
- R6: When a clear strobe and a new setting event fall in the same cycle, the event wins and the flag stays set. This holds for `clr_edge` against a new transition, and for `clr_ovf` against a new overflow.
- R7: `irq` = `irq_master_en` AND ((`irq_rise_en` AND `rise_sts`) OR (`irq_fall_en` AND `fall_sts`) OR (`irq_ovf_en` AND `ovf_sts`)). It follows its inputs with no added register.
- R8: From the clock edge that records a transition, `trig_out` equals `trig_sel` for exactly ceil(PULSE_NS/CLK_NS) cycles (20 with the defaults) and is 0 otherwise.
- R9: A transition detected while a trigger pulse is running restarts the full pulse length from that clock edge.
- R10: The first sample after reset only seeds the comparison. Lines that are already high when reset is released report no upward transition.
- R11: After reset all status flags, `irq` and `trig_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | NPORTS*8 | Synchronized port lines, port p in bits p*8+7..p*8 |
| rise_en | input | NPORTS*8 | Per-line enable for 0-to-1 transitions |
| fall_en | input | NPORTS*8 | Per-line enable for 1-to-0 transitions |
| clr_edge | input | 1 | Strobe that clears the transition status flags |
| clr_ovf | input | 1 | Strobe that clears the overflow flag |
| irq_master_en | input | 1 | Global interrupt enable |
| irq_rise_en | input | 1 | Interrupt source enable for upward transitions |
| irq_fall_en | input | 1 | Interrupt source enable for downward transitions |
| irq_ovf_en | input | 1 | Interrupt source enable for overflow |
| trig_sel | input | NTRIG | Trigger lines that carry the pulse |
| rise_sts | output | 1 | Sticky upward-transition flag |
| fall_sts | output | 1 | Sticky downward-transition flag |
| edge_sts | output | 1 | Sticky flag for any transition |
| ovf_sts | output | 1 | Sticky missed-transition flag |
| irq | output | 1 | Interrupt request |
| trig_out | output | NTRIG | Trigger pulse outputs |

## Verification
Single transitions are applied on lines of different ports in each direction. This tells the upward and downward masks apart, and a transition against a cleared enable bit shows that the masks really gate detection. Back-to-back transitions, and transitions placed in the same cycle as a clear strobe, separate overflow detection and event-over-clear priority from the plain sticky behaviour. Trigger pulses are counted cycle by cycle, both alone and with a second transition in mid-pulse, to pin down the exact length and the restart. Lines held high across reset release show that the first sample only seeds the comparison.

// File: rtl/edgemon_pkg.sv
package edgemon_pkg;

  localparam int LINE_W = 8;

  typedef logic [LINE_W-1:0] line_t;

  // Clock cycles needed to cover a pulse of pulse_ns, rounded up, at least one.
  function automatic int unsigned pulse_cycles(int unsigned pulse_ns, int unsigned clk_ns);
    int unsigned r;
    r = (pulse_ns + clk_ns - 1) / clk_ns;
    if (r == 0) r = 1;
    return r;
  endfunction

  // Enabled upward transitions between two samples.
  function automatic line_t up_hits(line_t cur, line_t prev, line_t en);
    return cur & ~prev & en;
  endfunction

  // Enabled downward transitions between two samples.
  function automatic line_t down_hits(line_t cur, line_t prev, line_t en);
    return ~cur & prev & en;
  endfunction

  // Interrupt level from flags and gates.
  function automatic logic irq_level(logic master, logic en_r, logic en_f, logic en_o,
                                     logic sts_r, logic sts_f, logic sts_o);
    return master & ((en_r & sts_r) | (en_f & sts_f) | (en_o & sts_o));
  endfunction

endpackage

// File: rtl/edgemon_port.sv
module edgemon_port
  import edgemon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm,
  input  line_t cur,
  input  line_t rise_en,
  input  line_t fall_en,
  output line_t rise_hit,
  output line_t fall_hit
);

  line_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  always_comb begin
    rise_hit = arm ? up_hits(cur, prev_q, rise_en)   : '0;
    fall_hit = arm ? down_hits(cur, prev_q, fall_en) : '0;
  end

endmodule

// File: rtl/edgemon_status.sv
module edgemon_status (
  input  logic clk,
  input  logic rst_n,
  input  logic any_rise,
  input  logic any_fall,
  input  logic clr_edge,
  input  logic clr_ovf,
  output logic rise_sts,
  output logic fall_sts,
  output logic ovf_sts,
  output logic ovf_hit
);

  logic rise_q, fall_q, ovf_q;

  assign ovf_hit = (any_rise | any_fall) & (rise_q | fall_q);

  // A setting event takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (any_rise)      rise_q <= 1'b1;
      else if (clr_edge) rise_q <= 1'b0;
      if (any_fall)      fall_q <= 1'b1;
      else if (clr_edge) fall_q <= 1'b0;
      if (ovf_hit)       ovf_q  <= 1'b1;
      else if (clr_ovf)  ovf_q  <= 1'b0;
    end
  end

  assign rise_sts = rise_q;
  assign fall_sts = fall_q;
  assign ovf_sts  = ovf_q;

endmodule

// File: rtl/edgemon_pulse.sv
module edgemon_pulse #(
  parameter int CYC   = 20,
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [NTRIG-1:0] trig_sel,
  output logic             active,
  output logic [NTRIG-1:0] trig_out
);

  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (fire)         cnt_q <= CNT_W'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active   = (cnt_q != '0);
  assign trig_out = active ? trig_sel : '0;

endmodule

// File: rtl/edgemon_top.sv
module edgemon_top
  import edgemon_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int NTRIG    = 4,
  parameter int CLK_NS   = 10,
  parameter int PULSE_NS = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*LINE_W-1:0] port_in,
  input  logic [NPORTS*LINE_W-1:0] rise_en,
  input  logic [NPORTS*LINE_W-1:0] fall_en,
  input  logic                     clr_edge,
  input  logic                     clr_ovf,
  input  logic                     irq_master_en,
  input  logic                     irq_rise_en,
  input  logic                     irq_fall_en,
  input  logic                     irq_ovf_en,
  input  logic [NTRIG-1:0]         trig_sel,
  output logic                     rise_sts,
  output logic                     fall_sts,
  output logic                     edge_sts,
  output logic                     ovf_sts,
  output logic                     irq,
  output logic [NTRIG-1:0]         trig_out
);

  localparam int BUS_W     = NPORTS * LINE_W;
  localparam int PULSE_CYC = int'(pulse_cycles(PULSE_NS, CLK_NS));

  logic             arm_q;
  logic [BUS_W-1:0] rise_hit_w, fall_hit_w;
  logic             any_rise_w, any_fall_w, any_hit_w, ovf_hit_w, trig_active_w;

  // The first sample after reset only seeds the comparison registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= 1'b1;
  end

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    edgemon_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_q),
      .cur      (port_in[gp*LINE_W +: LINE_W]),
      .rise_en  (rise_en[gp*LINE_W +: LINE_W]),
      .fall_en  (fall_en[gp*LINE_W +: LINE_W]),
      .rise_hit (rise_hit_w[gp*LINE_W +: LINE_W]),
      .fall_hit (fall_hit_w[gp*LINE_W +: LINE_W])
    );
  end

  assign any_rise_w = |rise_hit_w;
  assign any_fall_w = |fall_hit_w;
  assign any_hit_w  = any_rise_w | any_fall_w;

  edgemon_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_rise (any_rise_w),
    .any_fall (any_fall_w),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf),
    .rise_sts (rise_sts),
    .fall_sts (fall_sts),
    .ovf_sts  (ovf_sts),
    .ovf_hit  (ovf_hit_w)
  );

  assign edge_sts = rise_sts | fall_sts;

  assign irq = irq_level(irq_master_en, irq_rise_en, irq_fall_en, irq_ovf_en,
                         rise_sts, fall_sts, ovf_sts);

  edgemon_pulse #(.CYC(PULSE_CYC), .NTRIG(NTRIG)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (any_hit_w),
    .trig_sel (trig_sel),
    .active   (trig_active_w),
    .trig_out (trig_out)
  );

endmodule

// File: rtl/edgemon_checker.sv
module edgemon_checker #(
  parameter int NTRIG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             any_hit_w,
  input logic             ovf_hit_w,
  input logic             clr_edge,
  input logic             clr_ovf,
  input logic             edge_sts,
  input logic             ovf_sts,
  input logic             irq,
  input logic             irq_master_en,
  input logic             trig_active_w,
  input logic [NTRIG-1:0] trig_out
);

  assert_hit_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit_w |=> edge_sts);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sts && !clr_edge) |=> edge_sts);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !any_hit_w) |=> !edge_sts);

  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit_w && edge_sts) |=> ovf_sts);

  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_hit_w) |=> !ovf_sts);

  assert_ovf_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && ovf_hit_w) |=> ovf_sts);

  assert_irq_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_master_en |-> !irq);

  assert_trig_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit_w |=> trig_active_w);

  assert_trig_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_active_w |-> (trig_out == '0));

endmodule

bind edgemon_top edgemon_checker #(.NTRIG(NTRIG)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .any_hit_w     (any_hit_w),
  .ovf_hit_w     (ovf_hit_w),
  .clr_edge      (clr_edge),
  .clr_ovf       (clr_ovf),
  .edge_sts      (edge_sts),
  .ovf_sts       (ovf_sts),
  .irq           (irq),
  .irq_master_en (irq_master_en),
  .trig_active_w (trig_active_w),
  .trig_out      (trig_out)
);

// File: tb/edgemon_top_bench.sv
module edgemon_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPORTS     = 4;
  localparam int NTRIG      = 4;
  localparam int BUS_W      = NPORTS * 8;
  localparam int PULSE_LEN  = (200 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [BUS_W-1:0] port_in = '0, rise_en = '0, fall_en = '0;
  logic             clr_edge = 1'b0, clr_ovf = 1'b0;
  logic             irq_master_en = 1'b0, irq_rise_en = 1'b0, irq_fall_en = 1'b0, irq_ovf_en = 1'b0;
  logic [NTRIG-1:0] trig_sel = '0;
  logic             rise_sts, fall_sts, edge_sts, ovf_sts, irq;
  logic [NTRIG-1:0] trig_out;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edgemon_top #(.NPORTS(NPORTS), .NTRIG(NTRIG), .CLK_NS(CLK_PERIOD), .PULSE_NS(200)) u_edgemon_top (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .rise_en(rise_en), .fall_en(fall_en),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf), .irq_master_en(irq_master_en),
    .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en), .irq_ovf_en(irq_ovf_en),
    .trig_sel(trig_sel), .rise_sts(rise_sts), .fall_sts(fall_sts), .edge_sts(edge_sts),
    .ovf_sts(ovf_sts), .irq(irq), .trig_out(trig_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int idx(int p, int b);
    return p * 8 + b;
  endfunction

  // Strobe clr_edge and clr_ovf for one cycle and wait out any pulse.
  task automatic clean_up();
    clr_edge = 1'b1; clr_ovf = 1'b1;
    tick(1);
    clr_edge = 1'b0; clr_ovf = 1'b0;
    tick(PULSE_LEN + 2);
  endtask

  task automatic t_reset_seed();
    port_in[idx(0,0) +: 4] = 4'hF;
    rise_en[idx(0,0) +: 8] = 8'hFF;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R11 reset edge_sts", edge_sts, 0);
    chk("R11 reset ovf/irq/trig", {ovf_sts, irq, trig_out}, 0);
    tick(3);
    chk("R10 no edge from first sample", {rise_sts, edge_sts}, 0);
    port_in[idx(0,0) +: 4] = 4'h0;   // falling, not enabled
    tick(1);
    chk("R3 disabled falling ignored", {fall_sts, edge_sts}, 0);
    chk("R3 no trigger", trig_out, 0);
    rise_en = '0;
  endtask

  task automatic t_rise();
    trig_sel = 4'b0001;
    rise_en[idx(1,3)] = 1'b1;
    port_in[idx(1,3)] = 1'b1;
    tick(1);
    chk("R1 rise_sts", {rise_sts, fall_sts, edge_sts, ovf_sts}, 4'b1010);
    tick(4);
    chk("R4 status sticky", edge_sts, 1);
    clr_edge = 1'b1; tick(1); clr_edge = 1'b0;
    chk("R4 clear", {rise_sts, fall_sts, edge_sts}, 0);
    port_in[idx(1,3)] = 1'b0;
    tick(1);
    chk("R3 fall on rise-only line", edge_sts, 0);
    rise_en = '0;
    clean_up();
  endtask

  task automatic t_fall_both();
    fall_en[idx(2,7)] = 1'b1;
    port_in[idx(2,7)] = 1'b1;
    tick(1);
    chk("R3 rise on fall-only line", edge_sts, 0);
    port_in[idx(2,7)] = 1'b0;
    tick(1);
    chk("R2 fall_sts", {rise_sts, fall_sts, edge_sts}, 3'b011);
    clean_up();
    rise_en[idx(3,0)] = 1'b1; fall_en[idx(3,0)] = 1'b1;
    port_in[idx(3,0)] = 1'b1;
    tick(1);
    port_in[idx(3,0)] = 1'b0;
    tick(1);
    chk("R2 both directions", {rise_sts, fall_sts}, 2'b11);
    rise_en = '0; fall_en = '0;
    clean_up();
  endtask

  task automatic t_overflow();
    rise_en[idx(0,5)] = 1'b1; rise_en[idx(0,6)] = 1'b1;
    port_in[idx(0,5)] = 1'b1;
    tick(1);
    chk("R5 no ovf on first edge", ovf_sts, 0);
    port_in[idx(0,6)] = 1'b1;
    tick(1);
    chk("R5 ovf on second edge", ovf_sts, 1);
    clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0;
    chk("R5 clr_ovf", {ovf_sts, edge_sts}, 2'b01);
    // Clear and a new edge in the same cycle: edge wins, and it overflows.
    port_in[idx(0,5)] = 1'b0; port_in[idx(0,6)] = 1'b0;
    tick(1);
    port_in[idx(0,5)] = 1'b1; clr_edge = 1'b1;
    tick(1);
    clr_edge = 1'b0;
    chk("R6 edge wins over clr_edge", {edge_sts, ovf_sts}, 2'b11);
    port_in[idx(0,6)] = 1'b1; clr_ovf = 1'b1;
    tick(1);
    clr_ovf = 1'b0;
    chk("R6 ovf wins over clr_ovf", ovf_sts, 1);
    port_in[idx(0,5)] = 1'b0; port_in[idx(0,6)] = 1'b0;
    rise_en = '0;
    clean_up();
    chk("R4 R5 all cleared", {edge_sts, ovf_sts}, 0);
  endtask

  task automatic t_irq();
    fall_en[idx(1,1)] = 1'b1;
    port_in[idx(1,1)] = 1'b1; tick(1);
    port_in[idx(1,1)] = 1'b0; tick(1);
    irq_fall_en = 1'b1; irq_rise_en = 1'b1; irq_ovf_en = 1'b1; #1;
    chk("R7 master off", irq, 0);
    irq_master_en = 1'b1; #1;
    chk("R7 fall source", irq, 1);
    irq_fall_en = 1'b0; #1;
    chk("R7 rise source only, no rise status", irq, 0);
    port_in[idx(1,1)] = 1'b1; tick(1);
    port_in[idx(1,1)] = 1'b0; tick(1);
    irq_rise_en = 1'b0; #1;
    chk("R7 ovf source", {ovf_sts, irq}, 2'b11);
    irq_ovf_en = 1'b0; #1;
    chk("R7 all sources off", irq, 0);
    irq_master_en = 1'b0; fall_en = '0;
    clean_up();
  endtask

  task automatic t_pulse();
    int on_cnt;
    int first_off;
    trig_sel = 4'b1010;
    rise_en[idx(2,2)] = 1'b1;
    port_in[idx(2,2)] = 1'b1;
    on_cnt = 0; first_off = 0;
    for (int i = 1; i <= PULSE_LEN + 4; i++) begin
      tick(1);
      if (trig_out == trig_sel) on_cnt++;
      else if (trig_out != 0) chk("R8 trig pattern", trig_out, trig_sel);
      if (trig_out == 0 && first_off == 0) first_off = i;
    end
    chk("R8 pulse length", on_cnt, PULSE_LEN);
    chk("R8 pulse ends", first_off, PULSE_LEN + 1);
    port_in[idx(2,2)] = 1'b0;
    clean_up();
    // Retrigger in mid-pulse.
    port_in[idx(2,2)] = 1'b1;
    tick(10);
    port_in[idx(2,2)] = 1'b0;
    rise_en[idx(2,2)] = 1'b0; fall_en[idx(2,2)] = 1'b1;
    on_cnt = 0;
    for (int i = 1; i <= PULSE_LEN + 4; i++) begin
      tick(1);
      if (trig_out == trig_sel) on_cnt++;
    end
    chk("R9 restart length", on_cnt, PULSE_LEN);
    rise_en = '0; fall_en = '0;
    clean_up();
  endtask

  initial begin
    fork
      begin
        t_reset_seed();
        t_rise();
        t_fall_both();
        t_overflow();
        t_irq();
        t_pulse();
      end
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule